// File: doc/BRIEF.md
# Eight-Bit Single-Slope PWM Timer

This block is an 8-bit up-counting timer that drives two pulse-width-modulated outputs, channel A and channel B. A prescaler turns the system clock into timer ticks. On each tick the counter advances until it reaches a terminal value. On the following tick it returns to zero. The terminal value is either the full count (255) or the active compare value of channel A. Each time the counter reaches the terminal value, an overflow flag is set and the compare values staged by software become active.

Each channel has a 2-bit mode that selects the waveform. The choices are off, toggle-on-match (channel A only), non-inverted PWM and inverted PWM. Software configures the block through a plain register write port and acknowledges the overflow flag with a clear pulse. An interrupt request follows the flag whenever the interrupt is enabled. There is no streamed data path, so every pin is a plain control or status signal without valid/ready handshaking.

Top module: `pwm_timer8`

## Requirements
- R1: After reset both waveform outputs and the interrupt request are low, the counter and all compare values are 0, and the timer is stopped.
- R2: Register 2 bits [6:4] select the prescale: values 1, 2, 3, 4 and 5 give one timer tick every 1, 8, 64, 256 and 1024 clocks. Values 0, 6 and 7 stop the timer and hold the prescale divider at zero.
- R3: On each tick the counter increments by one. On the tick where it equals TOP it returns to 0 instead. With TOP = 255 and divide-by-8, the overflow flag sets once every 2048 clocks.
- R4: Register 2 bit 7 clear makes TOP = 255. Bit 7 set makes TOP equal to the active channel A compare value.
- R5: Writes to register 0 (channel A compare) and register 1 (channel B compare) go to staging buffers. A staged value becomes active only on the tick where the counter wraps from TOP, so the period in progress is unchanged by the write.
- R6: The overflow flag sets on the wrap tick and stays set until `flag_clr` is high at a clock edge. If a wrap and a clear coincide, the flag is set.
- R7: `irq` is high exactly when the overflow flag is set and register 3 bit 0 (interrupt enable) is 1.
- R8: Mode 2 (register 2 bits [1:0] for A, bits [3:2] for B) is non-inverted PWM: the output is high while the counter is at or below the channel's active compare value and low above it.
- R9: Mode 3 is inverted PWM: the output is the complement of mode 2.
- R10: Mode 0 holds the output low. Mode 1 on channel B holds it low. Mode 1 on channel A holds it low while register 2 bit 7 is clear.
- R11: Mode 1 on channel A with register 2 bit 7 set inverts the output once for each tick on which the counter equals the active A compare value.
- R12: In mode 2 an active compare value of 0 gives a high pulse of exactly one tick per period. A value of 255 gives a constant high in mode 2 and a constant low in mode 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 compare A, 1 compare B, 2 control, 3 interrupt enable |
| wr_data | input | 8 | Register write data |
| flag_clr | input | 1 | Pulse high to clear the overflow flag |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| irq | output | 1 | Interrupt request |

## Verification
A wrong counter or prescale divider moves the flag spacing and the PWM edge positions. This shows at `irq` and at both waveforms within one period. A compare value that is loaded too early changes the duty or period of the current period rather than the next one, which the flag-interval and duty checks catch in the first affected period. A wrong toggle state or polarity shows as an inverted or frozen output on the next tick. A flag that drops without a clear shows at `irq` on the following clock.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_TOGGLE  = 2'd1,
    MODE_PWM     = 2'd2,
    MODE_PWM_INV = 2'd3
  } wave_mode_e;

  localparam logic [1:0] ADDR_CMP_A = 2'd0;
  localparam logic [1:0] ADDR_CMP_B = 2'd1;
  localparam logic [1:0] ADDR_CTL   = 2'd2;
  localparam logic [1:0] ADDR_IEN   = 2'd3;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PS_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PS_W-1:0] div_q;
  logic [PS_W-1:0] lim;
  logic            run;

  always_comb begin
    run = 1'b1;
    unique case (sel)
      3'd1: lim = PS_W'(0);
      3'd2: lim = PS_W'(7);
      3'd3: lim = PS_W'(63);
      3'd4: lim = PS_W'(255);
      3'd5: lim = PS_W'(1023);
      default: begin
        lim = '0;
        run = 1'b0;
      end
    endcase
  end

  assign tick = run && (div_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_q <= '0;
    else if (!run)     div_q <= '0;
    else if (tick)     div_q <= '0;
    else               div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          top_sel,
  input  logic [CW-1:0] buf_a,
  input  logic [CW-1:0] buf_b,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nx,
  output logic [CW-1:0] ocr_a_q,
  output logic [CW-1:0] ocr_b_q,
  output logic [CW-1:0] ocr_a_nx,
  output logic [CW-1:0] ocr_b_nx,
  output logic          wrap
);
  logic [CW-1:0] top_val;

  always_comb begin
    top_val  = top_sel ? ocr_a_q : '1;
    wrap     = tick && (cnt_q == top_val);
    if (!tick)      cnt_nx = cnt_q;
    else if (wrap)  cnt_nx = '0;
    else            cnt_nx = cnt_q + 1'b1;
    ocr_a_nx = wrap ? buf_a : ocr_a_q;
    ocr_b_nx = wrap ? buf_b : ocr_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ocr_a_q <= '0;
      ocr_b_q <= '0;
    end else begin
      cnt_q   <= cnt_nx;
      ocr_a_q <= ocr_a_nx;
      ocr_b_q <= ocr_b_nx;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int CW        = 8,
  parameter bit TOGGLE_OK = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wave_mode_e    mode_nx,
  input  logic          tog_en_nx,
  input  logic          match,
  input  logic [CW-1:0] cnt_nx,
  input  logic [CW-1:0] ocr_nx,
  output logic          wave
);
  logic wave_nx;

  always_comb begin
    unique case (mode_nx)
      MODE_PWM:     wave_nx = (cnt_nx <= ocr_nx);
      MODE_PWM_INV: wave_nx = !(cnt_nx <= ocr_nx);
      MODE_TOGGLE:  wave_nx = (TOGGLE_OK && tog_en_nx) ? (wave ^ match) : 1'b0;
      default:      wave_nx = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave <= 1'b0;
    else        wave <= wave_nx;
  end
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwm_pkg::*;
#(
  parameter int CW   = 8,
  parameter int PS_W = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          flag_clr,
  output logic          wave_a,
  output logic          wave_b,
  output logic          irq
);
  logic [CW-1:0] buf_a_q, buf_b_q;
  logic [7:0]    ctl_q, ctl_nx;
  logic          ien_q;
  logic          ovf_q;
  logic          tick, wrap;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic [CW-1:0] ocr_a_q, ocr_b_q, ocr_a_nx, ocr_b_nx;

  assign ctl_nx = (wr_en && wr_addr == ADDR_CTL) ? wr_data[7:0] : ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_a_q <= '0;
      buf_b_q <= '0;
      ctl_q   <= '0;
      ien_q   <= 1'b0;
    end else begin
      ctl_q <= ctl_nx;
      if (wr_en && wr_addr == ADDR_CMP_A) buf_a_q <= wr_data;
      if (wr_en && wr_addr == ADDR_CMP_B) buf_b_q <= wr_data;
      if (wr_en && wr_addr == ADDR_IEN)   ien_q   <= wr_data[0];
    end
  end

  pwm_prescaler #(.PS_W(PS_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .sel(ctl_q[6:4]), .tick(tick)
  );

  pwm_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .top_sel(ctl_q[7]),
    .buf_a(buf_a_q), .buf_b(buf_b_q),
    .cnt_q(cnt_q), .cnt_nx(cnt_nx),
    .ocr_a_q(ocr_a_q), .ocr_b_q(ocr_b_q),
    .ocr_a_nx(ocr_a_nx), .ocr_b_nx(ocr_b_nx),
    .wrap(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_q <= 1'b0;
    else if (wrap)     ovf_q <= 1'b1;
    else if (flag_clr) ovf_q <= 1'b0;
  end

  assign irq = ovf_q & ien_q;

  logic [NUM_CH-1:0][CW-1:0] ocr_q_arr, ocr_nx_arr;
  logic [NUM_CH-1:0][1:0]    mode_arr;
  logic [NUM_CH-1:0]         wave_arr;

  assign ocr_q_arr  = {ocr_b_q, ocr_a_q};
  assign ocr_nx_arr = {ocr_b_nx, ocr_a_nx};
  assign mode_arr   = {ctl_nx[3:2], ctl_nx[1:0]};

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    pwm_channel #(.CW(CW), .TOGGLE_OK(i == 0)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .mode_nx(wave_mode_e'(mode_arr[i])),
      .tog_en_nx(ctl_nx[7]),
      .match(tick && (cnt_q == ocr_q_arr[i])),
      .cnt_nx(cnt_nx), .ocr_nx(ocr_nx_arr[i]),
      .wave(wave_arr[i])
    );
  end

  assign wave_a = wave_arr[0];
  assign wave_b = wave_arr[1];
endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flag_clr,
  input logic          wave_a,
  input logic          wave_b,
  input logic          tick,
  input logic          wrap,
  input logic [CW-1:0] cnt,
  input logic [7:0]    ctl,
  input logic [CW-1:0] ocr_a,
  input logic          ovf
);
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap) |=> cnt == CW'($past(cnt) + 1'b1));
  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt == '0);
  // R3
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  // R2
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[6:4] == 3'd0) |-> !tick);
  // R2
  div_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[6:4] == 3'd1) |-> tick);
  // R5
  buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(ocr_a));
  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf);
  // R6
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !flag_clr) |=> ovf);
  // R10
  b_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[3:2] inside {2'd0, 2'd1}) |-> !wave_b);
  // R12
  full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[1:0] == 2'd2 && ocr_a == '1) |-> wave_a);
endmodule

bind pwm_timer8 pwm_timer8_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr),
  .wave_a(wave_a), .wave_b(wave_b), .tick(tick), .wrap(wrap),
  .cnt(cnt_q), .ctl(ctl_q), .ocr_a(ocr_a_q), .ovf(ovf_q)
);

// File: tb/pwm_timer8_test.sv
module pwm_timer8_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       flag_clr = 1'b0;
  logic       wave_a, wave_b, irq;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pwm_timer8 uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .flag_clr(flag_clr),
    .wave_a(wave_a), .wave_b(wave_b), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  int         m_div;
  logic [7:0] m_cnt, m_oa, m_ob, m_ba, m_bb, m_ctl;
  bit         m_ien, m_flag, m_wa, m_wb;

  function automatic bit wave_fn(input logic [1:0] mode, input bit is_a, input bit tsel,
                                 input logic [7:0] c, input logic [7:0] o,
                                 input bit prev, input bit match);
    case (mode)
      2'd2: return c <= o;
      2'd3: return !(c <= o);
      2'd1: return (is_a && tsel) ? (prev ^ match) : 1'b0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [1:0] mode, input bit is_a, input bit tsel);
    if (mode == 2'd2) return "R8";
    if (mode == 2'd3) return "R9";
    if (mode == 2'd1 && is_a && tsel) return "R11";
    return "R10";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_oa = 0; m_ob = 0; m_ba = 0; m_bb = 0;
      m_ctl = 0; m_ien = 0; m_flag = 0; m_wa = 0; m_wb = 0;
    end else begin
      int lim; bit run, tck, wrp, ma; logic [7:0] top;
      run = 1'b1;
      case (m_ctl[6:4])
        3'd1: lim = 0;
        3'd2: lim = 7;
        3'd3: lim = 63;
        3'd4: lim = 255;
        3'd5: lim = 1023;
        default: begin lim = 0; run = 1'b0; end
      endcase
      tck   = run && (m_div >= lim);
      m_div = (!run || tck) ? 0 : m_div + 1;
      top   = m_ctl[7] ? m_oa : 8'hFF;
      wrp   = tck && (m_cnt == top);
      ma    = tck && (m_cnt == m_oa);
      if (tck) m_cnt = wrp ? 8'd0 : m_cnt + 8'd1;
      if (wrp) begin m_oa = m_ba; m_ob = m_bb; end
      if (wrp) m_flag = 1'b1; else if (flag_clr) m_flag = 1'b0;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_ba = wr_data;
          2'd1: m_bb = wr_data;
          2'd2: m_ctl = wr_data;
          default: m_ien = wr_data[0];
        endcase
      end
      m_wa = wave_fn(m_ctl[1:0], 1'b1, m_ctl[7], m_cnt, m_oa, m_wa, ma);
      m_wb = wave_fn(m_ctl[3:2], 1'b0, m_ctl[7], m_cnt, m_ob, m_wb, 1'b0);
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(wave_a == m_wa, tag_of(m_ctl[1:0], 1'b1, m_ctl[7]), wave_a, m_wa);
      chk(wave_b == m_wb, tag_of(m_ctl[3:2], 1'b0, m_ctl[7]), wave_b, m_wb);
      chk(irq == (m_flag && m_ien), "R6 R7 irq", irq, m_flag && m_ien);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wave_a) hi++;
    end
  endtask

  task automatic flag_gap(output int n);
    while (!irq) @(negedge clk);
    flag_clr = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) flag_clr = 1'b0;
    end while (!irq && n < 5000);
  endtask

  initial begin
    int hi, gap;
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(wave_a == 0 && wave_b == 0, "R1 waves", {wave_a, wave_b}, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    @(negedge clk); rst_n = 1'b1;
    cmp_on = 1'b1;
    // R2 stopped timer: interrupt enabled but no flag ever
    wr(2'd3, 8'h01);
    repeat (400) @(negedge clk);
    chk(irq == 0, "R2 stopped", irq, 0);

    // R12 spike: compare A = 0, mode 2, divide by 1, TOP 255
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h12);
    repeat (300) @(negedge clk);
    count_high(256, hi);
    chk(hi == 1, "R12 spike", hi, 1);

    // R12 constant: compare A = 255
    wr(2'd0, 8'hFF);
    repeat (300) @(negedge clk);
    count_high(256, hi);
    chk(hi == 256, "R12 const high", hi, 256);
    wr(2'd2, 8'h13);
    count_high(256, hi);
    chk(hi == 0, "R12 const low", hi, 0);

    // R3 period with TOP 255 and divide by 8
    wr(2'd2, 8'h22);
    clear_flag();
    flag_gap(gap);
    flag_gap(gap);
    chk(gap == 2048, "R3 period", gap, 2048);

    // R4 R5: TOP from compare A, staged write affects the next period only
    wr(2'd0, 8'd9);
    wr(2'd2, 8'h91);
    flag_gap(gap);
    flag_gap(gap);
    chk(gap == 10, "R4 top from A", gap, 10);
    while (!irq) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd3; flag_clr = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; flag_clr = 1'b0;
    gap = 1;
    while (!irq && gap < 5000) begin @(negedge clk); gap++; end
    chk(gap == 10, "R5 old period kept", gap, 10);
    flag_gap(gap);
    chk(gap == 4, "R5 new period", gap, 4);

    // R11 toggle: A inverts once per 4-tick period
    count_high(40, hi);
    chk(hi == 20, "R11 toggle duty", hi, 20);

    // random mix, checked every cycle against the model
    for (int s = 0; s < 60; s++) begin
      logic [7:0] ctl;
      ctl = $urandom;
      ctl[6:4] = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'($urandom % 2 + 1);
      wr(2'd0, ($urandom % 2) ? 8'($urandom % 24) : 8'($urandom));
      wr(2'd1, 8'($urandom));
      wr(2'd2, ctl);
      if ($urandom % 3 == 0) wr(2'd3, 8'($urandom % 2));
      for (int c = 0; c < 600; c++) begin
        @(negedge clk);
        flag_clr = ($urandom % 8 == 0);
      end
      flag_clr = 1'b0;
    end

    done = 1'b1;
    cmp_on = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule